// File: doc/BRIEF.md
# Pedestal DAC Endpoint Alignment Controller

This block aligns the endpoints of a pedestal DAC with the endpoints of an ADC under test. It does this by trimming two 12-bit correction values. The offset trim is handled first and the gain trim second. Each search has its own fixed test code. The controller writes the 16-bit test code into the code latches one byte at a time, and then writes the trim value to its channel latch. After that it pulses a load line, which moves both trim latches into their outputs together. It waits a programmable settle time and then samples two window-comparator flags. One flag reports that the integrator output is above the window and the other that it is below. The controller steps the trim by one toward the window and repeats until both flags are low.

A single bus carries all writes. A 2-bit select field picks the destination and a one-cycle write strobe commits the data. A successful calibration ends with the done output. If a search would have to step past either rail of the trim range, it stops with the error output set instead. A new start pulse from the done or error state runs the calibration again.

Top module: `ptc_align_ctrl`

## Requirements
- R1: After reset `wr_o`, `ld_o`, `done_o` and `err_o` are all low.
- R2: A start pulse first writes the offset test code 0xFFFE: low byte with select 00, then high byte with select 01, in two back-to-back cycles on `bus_o[7:0]`. The gain phase writes code 0x0000 the same way.
- R3: Offset trim writes use select 10 and gain trim writes use select 11, with the trim on `bus_o[11:0]`. The first trim write of each phase carries midscale 0x800 and follows the code high-byte write directly.
- R4: Every trim write is followed in the next cycle by a one-cycle `ld_o` pulse, and `ld_o` is never high together with `wr_o`.
- R5: The flags are sampled only after the settle time. Within one phase, consecutive `ld_o` pulses are exactly SETTLE_CYC+3 cycles apart.
- R6: With the default polarity, a high upper flag makes the next trim one less and a high lower flag makes it one more. Both flags low ends the phase, so each trim settles at the first value that brings the output inside the window.
- R7: No gain code or gain trim is written before the offset search has ended inside the window.
- R8: After the gain search ends inside the window, `done_o` goes high with `err_o` low. It stays high with no bus activity until the next start.
- R9: If a step would take the trim below 0x000 or above 0xFFF, `err_o` goes high and `done_o` stays low. No further writes or loads occur, and the gain phase is skipped when the offset search fails.
- R10: A start pulse while a calibration is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured in idle, done or error state |
| win_hi_i | input | 1 | Integrator output above window |
| win_lo_i | input | 1 | Integrator output below window |
| bus_o | output | TRIM_W | Shared write data (code byte in [7:0] or trim value) |
| sel_o | output | 2 | Write destination: 00 code low, 01 code high, 10 offset trim, 11 gain trim |
| wr_o | output | 1 | Write strobe, one cycle per write |
| ld_o | output | 1 | Transfers both trim latches to their outputs together |
| done_o | output | 1 | Calibration finished inside window |
| err_o | output | 1 | A trim search hit a rail |

## Verification
The assertions assume that the two comparator flags are never high in the same cycle. They also assume that the settle time covers the flag synchronizer depth, so that each sample reflects the most recent load. The bench drives both flags from one behavioural model. That model compares the trim last transferred by `ld_o` with a target through a symmetric window, so at most one flag is ever set. It changes the flags only on the falling edge of the cycle in which the load is seen. Targets are drawn around midscale, and some are placed at and beyond the rails to reach the error path.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  typedef enum logic [1:0] {
    SEL_CODE_LO   = 2'b00,
    SEL_CODE_HI   = 2'b01,
    SEL_TRIM_OFS  = 2'b10,
    SEL_TRIM_GAIN = 2'b11
  } sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CODE_LO,
    ST_CODE_HI,
    ST_TRIM_WR,
    ST_LOAD,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DONE,
    ST_ERR
  } state_e;

  typedef enum logic {
    PH_OFS  = 1'b0,
    PH_GAIN = 1'b1
  } phase_e;

endpackage

// File: rtl/ptc_flag_sync.sv
module ptc_flag_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ptc_settle_timer.sv
module ptc_settle_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic last_o
);

  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CNT_INIT;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // high in the final settle cycle
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ptc_trim_step.sv
module ptc_trim_step #(
  parameter int unsigned TRIM_W   = 12,
  parameter bit          UP_ON_HI = 1'b0
) (
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              above_i,
  input  logic              below_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              in_win_o,
  output logic              ovf_o
);

  logic inc, dec;

  // above wins if both flags are set
  if (UP_ON_HI) begin : g_inv
    assign inc = above_i;
    assign dec = below_i && !above_i;
  end else begin : g_dir
    assign dec = above_i;
    assign inc = below_i && !above_i;
  end

  assign in_win_o = !above_i && !below_i;
  assign ovf_o    = (inc && (trim_i == '1)) || (dec && (trim_i == '0));

  always_comb begin
    trim_o = trim_i;
    if (inc)      trim_o = trim_i + 1'b1;
    else if (dec) trim_o = trim_i - 1'b1;
  end

endmodule

// File: rtl/ptc_align_ctrl.sv
module ptc_align_ctrl
  import ptc_pkg::*;
#(
  parameter int unsigned TRIM_W      = 12,
  parameter int unsigned SETTLE_CYC  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          UP_ON_HI    = 1'b0,
  parameter logic [15:0] OFS_CODE    = 16'hFFFE,
  parameter logic [15:0] GAIN_CODE   = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              win_hi_i,
  input  logic              win_lo_i,
  output logic [TRIM_W-1:0] bus_o,
  output logic [1:0]        sel_o,
  output logic              wr_o,
  output logic              ld_o,
  output logic              done_o,
  output logic              err_o
);

  localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};

  state_e            state_q;
  phase_e            phase_q;
  logic [TRIM_W-1:0] trim_q;

  logic [1:0]        flags_s;
  logic              settle_last;
  logic [TRIM_W-1:0] trim_nxt;
  logic              in_win, ovf;
  logic [15:0]       code_cur;

  ptc_flag_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({win_hi_i, win_lo_i}),
    .q_o    (flags_s)
  );

  ptc_settle_timer #(
    .CYCLES (SETTLE_CYC)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_LOAD),
    .last_o (settle_last)
  );

  ptc_trim_step #(
    .TRIM_W   (TRIM_W),
    .UP_ON_HI (UP_ON_HI)
  ) u_step (
    .trim_i   (trim_q),
    .above_i  (flags_s[1]),
    .below_i  (flags_s[0]),
    .trim_o   (trim_nxt),
    .in_win_o (in_win),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OFS;
      trim_q  <= TRIM_MID;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            state_q <= ST_CODE_LO;
            phase_q <= PH_OFS;
            trim_q  <= TRIM_MID;
          end
        end
        ST_CODE_LO: state_q <= ST_CODE_HI;
        ST_CODE_HI: state_q <= ST_TRIM_WR;
        ST_TRIM_WR: state_q <= ST_LOAD;
        ST_LOAD:    state_q <= ST_SETTLE;
        ST_SETTLE:  if (settle_last) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (in_win) begin
            if (phase_q == PH_OFS) begin
              phase_q <= PH_GAIN;
              trim_q  <= TRIM_MID;
              state_q <= ST_CODE_LO;
            end else begin
              state_q <= ST_DONE;
            end
          end else if (ovf) begin
            state_q <= ST_ERR;
          end else begin
            trim_q  <= trim_nxt;
            state_q <= ST_TRIM_WR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign code_cur = (phase_q == PH_GAIN) ? GAIN_CODE : OFS_CODE;

  always_comb begin
    wr_o  = 1'b0;
    sel_o = SEL_CODE_LO;
    bus_o = '0;
    unique case (state_q)
      ST_CODE_LO: begin
        wr_o  = 1'b1;
        sel_o = SEL_CODE_LO;
        bus_o = TRIM_W'(code_cur[7:0]);
      end
      ST_CODE_HI: begin
        wr_o  = 1'b1;
        sel_o = SEL_CODE_HI;
        bus_o = TRIM_W'(code_cur[15:8]);
      end
      ST_TRIM_WR: begin
        wr_o  = 1'b1;
        sel_o = (phase_q == PH_GAIN) ? SEL_TRIM_GAIN : SEL_TRIM_OFS;
        bus_o = trim_q;
      end
      default: ;
    endcase
  end

  assign ld_o   = (state_q == ST_LOAD);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

endmodule

// File: rtl/ptc_align_chk.sv
module ptc_align_chk #(
  parameter int unsigned TRIM_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_hi_i,
  input logic              win_lo_i,
  input logic [TRIM_W-1:0] bus_o,
  input logic [1:0]        sel_o,
  input logic              wr_o,
  input logic              ld_o,
  input logic              done_o,
  input logic              err_o
);

  localparam logic [TRIM_W-1:0] TRIM_MID = {1'b1, {(TRIM_W-1){1'b0}}};

  logic              trim_wr;
  logic [TRIM_W-1:0] prev_q;
  logic [1:0]        prev_sel_q;
  logic              prev_v_q;

  assign trim_wr = wr_o && sel_o[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_sel_q <= 2'b00;
      prev_v_q   <= 1'b0;
    end else if (wr_o && sel_o == 2'b00) begin
      prev_v_q   <= 1'b0;
    end else if (trim_wr) begin
      prev_q     <= bus_o;
      prev_sel_q <= sel_o;
      prev_v_q   <= 1'b1;
    end
  end

  // input assumption: flags are mutually exclusive
  a_r6_flags_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_hi_i && win_lo_i));

  a_r2_code_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && sel_o == 2'b00) |=> (wr_o && sel_o == 2'b01));

  a_r3_mid_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && sel_o == 2'b01) |=> (trim_wr && bus_o == TRIM_MID));

  a_r4_ld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_wr |=> (ld_o && !wr_o));

  a_r4_ld_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> !wr_o);

  a_r6_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_wr && prev_v_q && prev_sel_q == sel_o) |->
      (bus_o == TRIM_W'(prev_q + 1'b1) || bus_o == TRIM_W'(prev_q - 1'b1)));

  a_r8_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_o && !ld_o));

  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!wr_o && !ld_o));

endmodule

bind ptc_align_ctrl ptc_align_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .win_hi_i (win_hi_i),
  .win_lo_i (win_lo_i),
  .bus_o    (bus_o),
  .sel_o    (sel_o),
  .wr_o     (wr_o),
  .ld_o     (ld_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/sim_ptc_align_ctrl.sv
`timescale 1ns/1ps
module sim_ptc_align_ctrl;

  localparam int TW = 12;
  localparam int S  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          hi = 1'b0;
  logic          lo = 1'b0;
  logic [TW-1:0] bus;
  logic [1:0]    sel;
  logic          wr, ld, done, err;

  ptc_align_ctrl #(.TRIM_W(TW), .SETTLE_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .win_hi_i(hi), .win_lo_i(lo),
    .bus_o(bus), .sel_o(sel), .wr_o(wr), .ld_o(ld),
    .done_o(done), .err_o(err)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_err = 0;

  // analog model and monitor state
  int tgt1, tgt2, w;
  int pend1, pend2, act1, act2, code_lo, code_hi;
  int wr1, wr2, code_wr, code_bad, order_bad, step_bad, gap_bad, pair_bad;
  int prev1, prev2, cur_ch, last_ld_ch, last_ld_cyc, cyc;
  bit ld_pend;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fin(input int t, input int ww);
    if (t - ww > 4095) return 4095;
    if (t + ww < 0)    return 0;
    if (t - ww > 2048) return t - ww;
    if (t + ww < 2048) return t + ww;
    return 2048;
  endfunction

  function automatic bit unreach(input int t, input int ww);
    return (t - ww > 4095) || (t + ww < 0);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit bad_step(input int nw, input int pv, input int t);
    if (pv < 0) return nw != 2048;
    return (iabs(nw - pv) != 1) || ((nw - pv) * (t - pv) <= 0);
  endfunction

  always @(negedge clk) begin
    int e, code, exp_b;
    cyc++;
    if (rst_n) begin
      if (ld_pend && !ld) pair_bad++;
      ld_pend = 1'b0;
      if (wr) begin
        case (sel)
          2'b00, 2'b01: begin
            if (code_wr < 2) exp_b = (sel == 2'b00) ? 'hFE : 'hFF;
            else             exp_b = 0;
            if (sel != 2'(code_wr % 2) || int'(bus) != exp_b) code_bad++;
            if (code_wr >= 2 && wr1 == 0) order_bad++;
            if (sel == 2'b00) code_lo = int'(bus[7:0]);
            else              code_hi = int'(bus[7:0]);
            code_wr++;
          end
          2'b10: begin
            if (wr2 > 0) order_bad++;
            if (bad_step(int'(bus), prev1, tgt1)) step_bad++;
            prev1 = int'(bus); pend1 = int'(bus); wr1++; cur_ch = 1; ld_pend = 1'b1;
          end
          default: begin
            if (code_wr < 4) order_bad++;
            if (bad_step(int'(bus), prev2, tgt2)) step_bad++;
            prev2 = int'(bus); pend2 = int'(bus); wr2++; cur_ch = 2; ld_pend = 1'b1;
          end
        endcase
      end
      if (ld) begin
        act1 = pend1; act2 = pend2;
        if (last_ld_ch == cur_ch && cyc - last_ld_cyc != S + 3) gap_bad++;
        last_ld_cyc = cyc; last_ld_ch = cur_ch;
        if (wr) pair_bad++;
      end
      code = code_hi * 256 + code_lo;
      if (code == 'hFFFE)   e = act1 - tgt1;
      else if (code == 0)   e = act2 - tgt2;
      else                  e = 0;
      hi <= (e > w);
      lo <= (e < -w);
    end
  end

  task automatic run_cal(input int t1, input int t2, input int ww, input bit mid_start);
    int n, f1, f2, s_wr, s_cw;
    tgt1 = t1; tgt2 = t2; w = ww;
    wr1 = 0; wr2 = 0; code_wr = 0; code_bad = 0; order_bad = 0;
    step_bad = 0; gap_bad = 0; pair_bad = 0;
    prev1 = -1; prev2 = -1; last_ld_ch = 0; cur_ch = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && !err && n < 60000) begin
      @(negedge clk);
      n++;
      start = mid_start && (n == 40);  // R10 stimulus
    end
    start = 1'b0;
    f1 = fin(t1, ww); f2 = fin(t2, ww);
    chk(pair_bad == 0, "R4 load pairing", pair_bad, 0);
    chk(step_bad == 0, "R6 step direction/size", step_bad, 0);
    chk(gap_bad == 0,  "R5 settle spacing", gap_bad, 0);
    chk(order_bad == 0, "R7 phase order", order_bad, 0);
    chk(code_bad == 0, "R2 code bytes", code_bad, 0);
    chk(act1 == f1, "R6 offset trim final", act1, f1);
    if (unreach(t1, ww)) begin
      chk(err == 1'b1 && done == 1'b0, "R9 offset rail error", {err, done}, 2);
      chk(wr2 == 0 && code_wr == 2, "R9 gain skipped", wr2 * 100 + code_wr, 2);
    end else begin
      chk(wr1 == iabs(f1 - 2048) + 1, "R3 offset writes", wr1, iabs(f1 - 2048) + 1);
      chk(code_wr == 4, mid_start ? "R10 restart ignored" : "R2 code writes", code_wr, 4);
      chk(act2 == f2, "R6 gain trim final", act2, f2);
      if (unreach(t2, ww))
        chk(err == 1'b1 && done == 1'b0, "R9 gain rail error", {err, done}, 2);
      else begin
        chk(done == 1'b1 && err == 1'b0, "R8 done", {done, err}, 2);
        chk(wr2 == iabs(f2 - 2048) + 1, "R3 gain writes", wr2, iabs(f2 - 2048) + 1);
      end
    end
    s_wr = wr1 + wr2; s_cw = code_wr;
    repeat (20) @(negedge clk);
    chk(wr1 + wr2 + code_wr == s_wr + s_cw && (done || err),
        err ? "R9 quiet after error" : "R8 done held", wr1 + wr2 + code_wr, s_wr + s_cw);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int t1, t2, ww;
    void'($urandom(32'd20240611));
    pend1 = 0; pend2 = 0; act1 = 0; act2 = 0; code_lo = 0; code_hi = 0; cyc = 0;
    repeat (3) @(negedge clk);
    chk(!wr && !ld && !done && !err, "R1 reset outputs", {wr, ld, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr && !ld && !done && !err, "R1 idle outputs", {wr, ld, done, err}, 0);
    // directed
    run_cal(2048, 2048, 2, 1'b0);
    run_cal(2051, 2045, 3, 1'b0);
    run_cal(2300, 1800, 1, 1'b1);
    // random
    for (int k = 0; k < 8; k++) begin
      t1 = 1848 + int'($urandom_range(0, 400));
      t2 = 1848 + int'($urandom_range(0, 400));
      ww = int'($urandom_range(0, 6));
      run_cal(t1, t2, ww, 1'b0);
    end
    // rails
    run_cal(4095, 2050, 0, 1'b0);
    run_cal(4200, 2048, 2, 1'b0);
    run_cal(2040, -30, 1, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule